// File: doc/BRIEF.md
# Legacy and MSI Interrupt Aggregator

This block gathers interrupt events for the host side of a bridge into one interrupt line. Four legacy wire interrupts (A to D) are sampled every clock. A message-signalled interrupt arrives as an inbound write on a separate doorbell port: when that write targets the fixed message address, its data names one of 32 vectors. Every event is latched in a sticky status bit, and software clears these bits by writing ones to them.

Status is kept at two levels. Each message vector has its own bit in a 32-bit vector status word. Any newly latched vector also sets a single summary bit in the local status word, next to the four wire bits. The interrupt output is the registered OR of the local status bits that are enabled in the local mask. Software reads the local word first, then the vector word, and clears the two levels separately. A host mask/status pair is also provided as plain storage at its own offsets. Nothing in this block sets the host status bits.

Top module: `intr_aggregator`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: The local mask (offset 0x180) and host mask (offset 0x188) read back exactly the 32-bit value last written.
- R3: If wire interrupt i (i = 0..3) is high at a rising edge, bit 24+i of the local status word (offset 0x184) is set and stays set until cleared.
- R4: A doorbell write to address 0x190 with data v, where v is below 32, sets bit v of the vector status word (offset 0x194) and the summary bit 28 of the local status word.
- R5: A doorbell write with data of 32 or more, or to any address other than 0x190, changes no status bit.
- R6: Writing to a status word clears exactly the bits written as one and leaves every other bit unchanged. Clearing the summary bit leaves the vector bits alone, and clearing vector bits leaves the summary bit alone.
- R7: When an event and a clear of the same status bit fall in the same cycle, the bit is set after that edge.
- R8: `irq_out` is high one cycle after any local status bit is set while its local mask bit is also set, and low one cycle after no such bit remains.
- R9: Local status bits outside 24..28, the host status word, the message address 0x190 and unmapped offsets all read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| db_valid | input | 1 | Inbound doorbell write strobe |
| db_addr | input | 12 | Doorbell write address |
| db_data | input | 32 | Doorbell write data (vector number) |
| intx_in | input | 4 | Legacy wire interrupts A..D |
| irq_out | output | 1 | Aggregated host interrupt |

## Verification
Two functions can meet in one cycle: an incoming event, either a doorbell write or a high wire, and a software write-one-to-clear of the very bit that event sets. The bench drives a doorbell for vector 7 and a clear of vector bit 7 on the same edge. It also holds a wire high while its status bit is cleared. Each case passes only if a later read of the status word still shows the bit set. A clear issued once the source is quiet must then return the bit to zero.

// File: rtl/intr_aggregator.sv
module intr_aggregator #(
  parameter int AW        = 12,
  parameter int NVEC      = 32,
  parameter int NINTX     = 4,
  parameter int INTX_LSB  = 24,
  parameter logic [AW-1:0] LMASK_OFS = 12'h180,
  parameter logic [AW-1:0] LSTAT_OFS = 12'h184,
  parameter logic [AW-1:0] HMASK_OFS = 12'h188,
  parameter logic [AW-1:0] HSTAT_OFS = 12'h18C,
  parameter logic [AW-1:0] MSG_OFS   = 12'h190,
  parameter logic [AW-1:0] VSTAT_OFS = 12'h194
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          db_valid,
  input  logic [AW-1:0] db_addr,
  input  logic [31:0]   db_data,
  input  logic [NINTX-1:0] intx_in,
  output logic          irq_out
);
  localparam int VW    = $clog2(NVEC);
  localparam int NLOC  = NINTX + 1;
  localparam int SUM_B = INTX_LSB + NINTX;

  logic [31:0]     lmask, hmask, hstat;
  logic [NLOC-1:0] lsrc;
  logic [NVEC-1:0] vstat;
  logic [31:0]     lword;
  logic            irq_q;

  wire db_ok = db_valid && (db_addr == MSG_OFS) && (db_data < NVEC);
  wire [NVEC-1:0] vec_set = db_ok ? (NVEC'(1) << db_data[VW-1:0]) : '0;
  wire [NLOC-1:0] loc_set = {db_ok, intx_in};

  wire wr_lmask = reg_we && reg_addr == LMASK_OFS;
  wire wr_lstat = reg_we && reg_addr == LSTAT_OFS;
  wire wr_hmask = reg_we && reg_addr == HMASK_OFS;
  wire wr_hstat = reg_we && reg_addr == HSTAT_OFS;
  wire wr_vstat = reg_we && reg_addr == VSTAT_OFS;

  wire [NLOC-1:0] loc_clr = wr_lstat ? reg_wdata[SUM_B:INTX_LSB] : '0;
  wire [NVEC-1:0] vec_clr = wr_vstat ? reg_wdata[NVEC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lmask <= '0;
      hmask <= '0;
      hstat <= '0;
      lsrc  <= '0;
      vstat <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_lmask) lmask <= reg_wdata;
      if (wr_hmask) hmask <= reg_wdata;
      if (wr_hstat) hstat <= hstat & ~reg_wdata;
      lsrc  <= (lsrc & ~loc_clr) | loc_set;
      vstat <= (vstat & ~vec_clr) | vec_set;
      irq_q <= |(lword & lmask);
    end
  end

  always_comb begin
    lword = '0;
    lword[SUM_B:INTX_LSB] = lsrc;
  end

  always_comb begin
    case (reg_addr)
      LMASK_OFS: reg_rdata = lmask;
      LSTAT_OFS: reg_rdata = lword;
      HMASK_OFS: reg_rdata = hmask;
      HSTAT_OFS: reg_rdata = hstat;
      VSTAT_OFS: reg_rdata = 32'(vstat);
      default:   reg_rdata = '0;
    endcase
  end

  assign irq_out = irq_q;

  // R8
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(lword & lmask)));

  // R4
  vec_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_ok |=> vstat[$past(db_data[VW-1:0])] && lword[SUM_B]);

  // R5
  db_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && !db_ok && !wr_vstat) |=> $stable(vstat));

  // R6
  vec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vstat && !db_valid) |=> (vstat & $past(reg_wdata[NVEC-1:0])) == '0);

  // R7
  intx_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intx_in[0] && wr_lstat && reg_wdata[INTX_LSB]) |=> lword[INTX_LSB]);
endmodule

// File: tb/intr_aggregator_tb.sv
module intr_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        db_valid = 1'b0;
  logic [11:0] db_addr = '0;
  logic [31:0] db_data = '0;
  logic [3:0]  intx_in = '0;
  logic        irq_out;

  always #5 clk = ~clk;

  intr_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_valid(db_valid),
    .db_addr(db_addr), .db_data(db_data), .intx_in(intx_in), .irq_out(irq_out)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    int          req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  initial forever begin
    @(posedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'b0, irq_out} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL R%0d: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic ring(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    db_addr = a; db_data = d; db_valid = 1'b1;
    @(posedge clk); #2;
    db_valid = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk);
    intx_in[i] = 1'b1;
    @(negedge clk);
    intx_in[i] = 1'b0;
  endtask

  task automatic exp_rd(input logic [11:0] a, input logic [31:0] e, input int r);
    item_t it;
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    it.is_irq = 1'b0; it.exp = e; it.req = r;
    q.push_back(it);
    @(posedge clk); #2;
  endtask

  task automatic exp_irq(input logic e, input int r);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.req = r;
    q.push_back(it);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    exp_rd(12'h180, 32'h0, 1);
    exp_rd(12'h184, 32'h0, 1);
    exp_rd(12'h188, 32'h0, 1);
    exp_rd(12'h194, 32'h0, 1);
    exp_irq(1'b0, 1);
    // R2 mask readback
    wr(12'h180, 32'h1F00_0000);
    exp_rd(12'h180, 32'h1F00_0000, 2);
    wr(12'h188, 32'hA5A5_0F0F);
    exp_rd(12'h188, 32'hA5A5_0F0F, 2);
    // R9 zero reads
    wr(12'h18C, 32'hFFFF_FFFF);
    exp_rd(12'h18C, 32'h0, 9);
    exp_rd(12'h190, 32'h0, 9);
    exp_rd(12'h1A0, 32'h0, 9);
    // R3 wire B pulse, R8 output
    pulse(1);
    exp_rd(12'h184, 32'h0200_0000, 3);
    exp_irq(1'b1, 8);
    // R6 clear
    wr(12'h184, 32'h0200_0000);
    exp_irq(1'b0, 8);
    exp_rd(12'h184, 32'h0, 6);
    // R8 masked source
    wr(12'h180, 32'h0100_0000);
    pulse(2);
    exp_rd(12'h184, 32'h0400_0000, 3);
    exp_irq(1'b0, 8);
    wr(12'h184, 32'h0400_0000);
    wr(12'h180, 32'h1F00_0000);
    // R4 doorbell vectors
    ring(12'h190, 32'd5);
    exp_rd(12'h194, 32'h0000_0020, 4);
    exp_rd(12'h184, 32'h1000_0000, 4);
    exp_irq(1'b1, 8);
    ring(12'h190, 32'd31);
    exp_rd(12'h194, 32'h8000_0020, 4);
    // R5 ignored doorbells
    ring(12'h190, 32'd32);
    ring(12'h190, 32'd40);
    ring(12'h194, 32'd3);
    exp_rd(12'h194, 32'h8000_0020, 5);
    // R6 separate levels
    wr(12'h184, 32'h1000_0000);
    exp_rd(12'h184, 32'h0, 6);
    exp_rd(12'h194, 32'h8000_0020, 6);
    exp_irq(1'b0, 8);
    wr(12'h194, 32'h0000_0020);
    exp_rd(12'h194, 32'h8000_0000, 6);
    wr(12'h194, 32'hFFFF_FFFF);
    exp_rd(12'h194, 32'h0, 6);
    // R7 doorbell and clear on one edge
    @(negedge clk);
    reg_addr = 12'h194; reg_wdata = 32'h0000_0080; reg_we = 1'b1;
    db_addr = 12'h190; db_data = 32'd7; db_valid = 1'b1;
    @(posedge clk); #2;
    reg_we = 1'b0; db_valid = 1'b0;
    exp_rd(12'h194, 32'h0000_0080, 7);
    wr(12'h194, 32'h0000_0080);
    exp_rd(12'h194, 32'h0, 7);
    wr(12'h184, 32'h1000_0000);
    // R7 held wire against clear
    @(negedge clk);
    intx_in[0] = 1'b1;
    wr(12'h184, 32'h0100_0000);
    exp_rd(12'h184, 32'h0100_0000, 7);
    @(negedge clk);
    intx_in[0] = 1'b0;
    wr(12'h184, 32'h0100_0000);
    exp_rd(12'h184, 32'h0, 7);
    // R8 mask zero blocks a pending bit
    pulse(3);
    wr(12'h180, 32'h0);
    exp_irq(1'b0, 8);
    exp_rd(12'h184, 32'h0800_0000, 3);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule